// File: doc/BRIEF.md
# Dual-Bus Word Memory With Byte Strobes

This block is a small on-chip memory with two independent ports. The instruction port only reads: it fetches one 16-bit word per cycle. In the same cycle, the data port can read or write. The storage is made of `N_BLK` banks, and each bank holds `BLK_WORDS` 16-bit words. The banks are laid end to end from word address zero. Both ports see exactly the same addresses. Code can therefore be placed in any bank, and data written through the data port can be fetched later as instructions.

The data port has three access widths:
- a 16-bit access;
- a 32-bit access to an aligned pair of words;
- a single-byte access to either the low or the high byte of a word.

Three strobe inputs choose the width. All read results come out one clock after the request, on registered outputs. An address that falls outside every bank returns zero and raises a miss pulse. A constant output gives the reset value for the stack pointer, which is the last word of the second bank.

Top module: `dbm_mem`

## Requirements
- R1: When `pf_req` is high at an in-range word address, `pf_rdata` on the next cycle holds that word. This happens whatever the data port does in the same cycle, unless R8 applies.
- R2: Bank k covers word addresses k*BLK_WORDS to (k+1)*BLK_WORDS-1 (by default 0x0000–0x03FF and 0x0400–0x07FF). Any word written through the data port can be read back at the same address through either port.
- R3: With `da_wide`=0, `da_lo`=1 and `da_hi`=1, the access is 16-bit. A write stores `da_wdata[15:0]`. A read returns the word in `da_rdata[15:0]` on the next cycle, with bits 31:16 at zero.
- R4: With `da_wide`=1 at an even address, the access is 32-bit and the byte strobes are ignored. The word at the address maps to bits 15:0 and the word at the address+1 maps to bits 31:16, for both read and write.
- R5: A 32-bit access at an odd in-range address writes nothing. On the next cycle it returns zero data and sets `da_align_err` for that one cycle.
- R6: A byte write (`da_wide`=0, exactly one of `da_lo`/`da_hi` set) stores `da_wdata[7:0]` into the selected byte: bits 7:0 for `da_lo`, bits 15:8 for `da_hi`. The other byte of the word keeps its value.
- R7: A byte read returns the selected byte in `da_rdata[7:0]`, with bits 31:8 at zero.
- R8: When the data port writes the word that the instruction port fetches in the same cycle, the fetch returns the value from before the write. The write is then visible from the next cycle on.
- R9: A request at an address at or above N_BLK*BLK_WORDS returns zero data and sets the miss output of its port for exactly one cycle. A write there changes no stored word.
- R10: `sp_init` equals 2*BLK_WORDS-1 (0x07FF by default).
- R11: After reset, and before any request, all data outputs and all flags are zero.
- R12: A data access with `da_wide`=0 and both byte strobes low writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of output registers |
| pf_req | input | 1 | Instruction fetch request |
| pf_addr | input | AW | Fetch word address |
| pf_rdata | output | 16 | Fetched word, one cycle after request |
| pf_miss | output | 1 | Fetch address outside all banks |
| da_req | input | 1 | Data access request |
| da_we | input | 1 | 1 = write, 0 = read |
| da_wide | input | 1 | 32-bit paired-word access |
| da_lo | input | 1 | Low-byte strobe |
| da_hi | input | 1 | High-byte strobe |
| da_addr | input | AW | Data word address |
| da_wdata | input | 32 | Write data |
| da_rdata | output | 32 | Read data, one cycle after request |
| da_miss | output | 1 | Data address outside all banks |
| da_align_err | output | 1 | 32-bit access at odd address |
| sp_init | output | AW | Reset stack-pointer value |

## Verification
The hardest case to reach from the ports is a same-cycle collision. In it, a data write lands on the very word being fetched. This includes the upper half of a 32-bit write, which hits address+1 rather than the address driven on the data port. The bench aims the fetch port at the written word, and also at its partner word, in the same cycle as the write. It then fetches again on the following cycle, so the old value and the new value are both seen. A full sweep writes a distinct computed pattern into every word of both banks. It then reads every word back through the instruction port while the data port reads a different word, which exposes any aliasing between banks or between ports.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0]   p_rdata;
        logic                p_miss;
        logic [2*WORD_W-1:0] d_rdata;
        logic                d_miss;
        logic                d_aerr;
    } dbm_resp_t;
endpackage

// File: rtl/dbm_decode.sv
module dbm_decode #(
    parameter int AW        = 16,
    parameter int BLK_WORDS = 1024,
    parameter int N_BLK     = 2
) (
    input  logic [AW-1:0]                          addr,
    output logic                                   hit,
    output logic [(N_BLK>1 ? $clog2(N_BLK) : 1)-1:0] sel,
    output logic [$clog2(BLK_WORDS)-1:0]           off
);
    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int SEL_W = (N_BLK > 1) ? $clog2(N_BLK) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(N_BLK * BLK_WORDS);

    always_comb begin
        hit = (addr < LIMIT);
        off = addr[OFF_W-1:0];
        sel = addr[OFF_W +: SEL_W];
    end
endmodule

// File: rtl/dbm_bank.sv
module dbm_bank #(
    parameter int WORDS = 1024
) (
    input  logic                     clk,
    input  logic [$clog2(WORDS)-1:0] ra_idx,
    output logic [15:0]              ra_data,
    input  logic [$clog2(WORDS)-1:0] rb_idx,
    output logic [15:0]              rb_lo,
    output logic [15:0]              rb_hi,
    input  logic [1:0]               wr_be0,
    input  logic [1:0]               wr_be1,
    input  logic [31:0]              wr_data
);
    localparam int OFF_W = $clog2(WORDS);

    logic [15:0] mem_q [WORDS];
    logic [OFF_W-1:0] pair_idx;

    always_comb begin
        pair_idx = {rb_idx[OFF_W-1:1], 1'b1};
        ra_data  = mem_q[ra_idx];
        rb_lo    = mem_q[rb_idx];
        rb_hi    = mem_q[pair_idx];
    end

    always_ff @(posedge clk) begin
        if (wr_be0[0]) mem_q[rb_idx][7:0]    <= wr_data[7:0];
        if (wr_be0[1]) mem_q[rb_idx][15:8]   <= wr_data[15:8];
        if (wr_be1[0]) mem_q[pair_idx][7:0]  <= wr_data[23:16];
        if (wr_be1[1]) mem_q[pair_idx][15:8] <= wr_data[31:24];
    end
endmodule

// File: rtl/dbm_mem.sv
module dbm_mem #(
    parameter int AW        = 16,
    parameter int BLK_WORDS = 1024,
    parameter int N_BLK     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_req,
    input  logic [AW-1:0] pf_addr,
    output logic [15:0]   pf_rdata,
    output logic          pf_miss,
    input  logic          da_req,
    input  logic          da_we,
    input  logic          da_wide,
    input  logic          da_lo,
    input  logic          da_hi,
    input  logic [AW-1:0] da_addr,
    input  logic [31:0]   da_wdata,
    output logic [31:0]   da_rdata,
    output logic          da_miss,
    output logic          da_align_err,
    output logic [AW-1:0] sp_init
);
    import dbm_pkg::*;

    localparam int OFF_W = $clog2(BLK_WORDS);
    localparam int SEL_W = (N_BLK > 1) ? $clog2(N_BLK) : 1;
    localparam logic [AW-1:0] LIMIT   = AW'(N_BLK * BLK_WORDS);
    localparam logic [AW-1:0] SP_INIT = AW'(2 * BLK_WORDS - 1);

    logic             p_hit, d_hit;
    logic [SEL_W-1:0] p_sel, d_sel;
    logic [OFF_W-1:0] p_off, d_off;

    dbm_decode #(.AW(AW), .BLK_WORDS(BLK_WORDS), .N_BLK(N_BLK)) u_pdec (
        .addr(pf_addr), .hit(p_hit), .sel(p_sel), .off(p_off)
    );
    dbm_decode #(.AW(AW), .BLK_WORDS(BLK_WORDS), .N_BLK(N_BLK)) u_ddec (
        .addr(da_addr), .hit(d_hit), .sel(d_sel), .off(d_off)
    );

    logic        d_odd_wide, d_ok, d_wr, d_rd, d_full;
    logic [1:0]  be0, be1;
    logic [31:0] wr_data;

    always_comb begin
        d_odd_wide = da_wide && da_addr[0];
        d_ok       = da_req && d_hit && !d_odd_wide;
        d_wr       = d_ok && da_we;
        d_rd       = d_ok && !da_we;
        d_full     = da_wide || (da_lo && da_hi);
        be0        = 2'b00;
        be1        = 2'b00;
        if (d_wr) begin
            be0 = da_wide ? 2'b11 : {da_hi, da_lo};
            be1 = da_wide ? 2'b11 : 2'b00;
        end
        wr_data[31:16] = da_wdata[31:16];
        wr_data[15:0]  = d_full ? da_wdata[15:0] : {da_wdata[7:0], da_wdata[7:0]};
    end

    logic [15:0] p_word [N_BLK];
    logic [15:0] d_lo   [N_BLK];
    logic [15:0] d_hi   [N_BLK];
    logic [1:0]  bk_be0 [N_BLK];
    logic [1:0]  bk_be1 [N_BLK];
    logic [N_BLK-1:0] bk_wr;

    for (genvar g = 0; g < N_BLK; g++) begin : g_bank
        always_comb begin
            bk_be0[g] = (d_sel == SEL_W'(g)) ? be0 : 2'b00;
            bk_be1[g] = (d_sel == SEL_W'(g)) ? be1 : 2'b00;
            bk_wr[g]  = |{bk_be0[g], bk_be1[g]};
        end
        dbm_bank #(.WORDS(BLK_WORDS)) u_bank (
            .clk    (clk),
            .ra_idx (p_off),
            .ra_data(p_word[g]),
            .rb_idx (d_off),
            .rb_lo  (d_lo[g]),
            .rb_hi  (d_hi[g]),
            .wr_be0 (bk_be0[g]),
            .wr_be1 (bk_be1[g]),
            .wr_data(wr_data)
        );
    end

    dbm_resp_t resp_d, resp_q;
    logic [15:0] sel_lo, sel_hi, sel_p;

    always_comb begin
        sel_p  = '0;
        sel_lo = '0;
        sel_hi = '0;
        for (int i = 0; i < N_BLK; i++) begin
            if (p_sel == SEL_W'(i)) sel_p = p_word[i];
            if (d_sel == SEL_W'(i)) begin
                sel_lo = d_lo[i];
                sel_hi = d_hi[i];
            end
        end

        resp_d         = '0;
        resp_d.p_miss  = pf_req && !p_hit;
        resp_d.p_rdata = (pf_req && p_hit) ? sel_p : '0;
        resp_d.d_miss  = da_req && !d_hit;
        resp_d.d_aerr  = da_req && d_hit && d_odd_wide;
        if (d_rd) begin
            if (da_wide)
                resp_d.d_rdata = {sel_hi, sel_lo};
            else if (da_lo && da_hi)
                resp_d.d_rdata = {16'h0000, sel_lo};
            else if (da_lo)
                resp_d.d_rdata = {24'h000000, sel_lo[7:0]};
            else if (da_hi)
                resp_d.d_rdata = {24'h000000, sel_lo[15:8]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign pf_rdata     = resp_q.p_rdata;
    assign pf_miss      = resp_q.p_miss;
    assign da_rdata     = resp_q.d_rdata;
    assign da_miss      = resp_q.d_miss;
    assign da_align_err = resp_q.d_aerr;
    assign sp_init      = SP_INIT;

    AST_FETCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req && pf_addr >= LIMIT) |=> (pf_miss && pf_rdata == 16'h0)); // R9
    AST_FETCH_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_req |=> !pf_miss); // R9
    AST_DATA_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (da_req && da_addr >= LIMIT) |=> (da_miss && !da_align_err && da_rdata == 32'h0)); // R9
    AST_ODD_WIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (da_req && da_wide && da_addr[0] && da_addr < LIMIT) |=> (da_align_err && da_rdata == 32'h0)); // R5
    AST_ODD_WIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_req && da_wide && da_addr[0]) |-> (bk_wr == '0)); // R5
    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (da_req && !da_we && !da_wide && (da_lo ^ da_hi)) |=> (da_rdata[31:8] == 24'h0)); // R7
endmodule

// File: tb/sim_dbm_mem.sv
module sim_dbm_mem;
    localparam int AW = 16;
    localparam int BW = 1024;
    localparam int NW = 2 * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_req = 1'b0;
    logic [AW-1:0] pf_addr = '0;
    logic [15:0]   pf_rdata;
    logic          pf_miss;
    logic          da_req = 1'b0, da_we = 1'b0, da_wide = 1'b0, da_lo = 1'b0, da_hi = 1'b0;
    logic [AW-1:0] da_addr = '0;
    logic [31:0]   da_wdata = '0;
    logic [31:0]   da_rdata;
    logic          da_miss, da_align_err;
    logic [AW-1:0] sp_init;

    int checks = 0;
    int errors = 0;
    logic [15:0] shadow [NW];

    always #5 clk = ~clk;

    dbm_mem #(.AW(AW), .BLK_WORDS(BW), .N_BLK(2)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pf_req(pf_req), .pf_addr(pf_addr), .pf_rdata(pf_rdata), .pf_miss(pf_miss),
        .da_req(da_req), .da_we(da_we), .da_wide(da_wide), .da_lo(da_lo), .da_hi(da_hi),
        .da_addr(da_addr), .da_wdata(da_wdata), .da_rdata(da_rdata),
        .da_miss(da_miss), .da_align_err(da_align_err), .sp_init(sp_init)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 40503) ^ 16'h5A5A ^ (a >> 3));
    endfunction

    // One cycle on both ports: drive, tick, compare with the model, update the model.
    task automatic xfer(input string tag, input bit pr, input int pa,
                        input bit dr, input bit we, input bit wide, input bit lo, input bit hi,
                        input int dad, input logic [31:0] wd);
        bit p_hit, d_hit, aerr, ok;
        logic [15:0] e_p, w0, w1;
        logic [31:0] e_d;
        p_hit = (pa < NW);
        d_hit = (dad < NW);
        aerr  = dr && d_hit && wide && dad[0];
        ok    = dr && d_hit && !(wide && dad[0]);
        e_p   = (pr && p_hit) ? shadow[pa] : 16'h0;
        e_d   = '0;
        if (ok && !we) begin
            w0 = shadow[dad];
            w1 = wide ? shadow[dad + 1] : 16'h0;
            if (wide)           e_d = {w1, w0};
            else if (lo && hi)  e_d = {16'h0, w0};
            else if (lo)        e_d = {24'h0, w0[7:0]};
            else if (hi)        e_d = {24'h0, w0[15:8]};
        end
        pf_req = pr; pf_addr = AW'(pa);
        da_req = dr; da_we = we; da_wide = wide; da_lo = lo; da_hi = hi;
        da_addr = AW'(dad); da_wdata = wd;
        @(negedge clk);
        chk(pf_rdata == e_p, {tag, " fetch data"}, 32'(pf_rdata), 32'(e_p));
        chk(pf_miss == (pr && !p_hit), {tag, " fetch miss"}, 32'(pf_miss), 32'(pr && !p_hit));
        chk(da_rdata == e_d, {tag, " data read"}, da_rdata, e_d);
        chk(da_miss == (dr && !d_hit), {tag, " data miss"}, 32'(da_miss), 32'(dr && !d_hit));
        chk(da_align_err == aerr, {tag, " align flag"}, 32'(da_align_err), 32'(aerr));
        if (ok && we) begin
            if (wide) begin
                shadow[dad] = wd[15:0];
                shadow[dad + 1] = wd[31:16];
            end else if (lo && hi) shadow[dad] = wd[15:0];
            else begin
                if (lo) shadow[dad][7:0]  = wd[7:0];
                if (hi) shadow[dad][15:8] = wd[7:0];
            end
        end
    endtask

    task automatic idle();
        xfer("idle", 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) shadow[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: outputs after reset
        chk(pf_rdata == 16'h0 && !pf_miss, "R11 fetch reset", 32'(pf_rdata), 32'h0);
        chk(da_rdata == 32'h0 && !da_miss && !da_align_err, "R11 data reset", da_rdata, 32'h0);
        // R10: stack pointer reset value
        chk(sp_init == 16'h07FF, "R10 sp_init", 32'(sp_init), 32'h07FF);

        // R3/R2: fill every word with 16-bit writes
        for (int a = 0; a < NW; a++)
            xfer("R3 fill", 1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, a, {16'hDEAD, pat(a)});
        // R1/R2: fetch every word while data port reads another
        for (int a = 0; a < NW; a++)
            xfer("R1 R2 sweep", 1'b1, a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, a ^ 16'h0555, 32'h0);

        // R4: 32-bit writes and reads, including bank edges
        for (int a = 0; a < NW; a += 62)
            xfer("R4 wide wr", 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a, {pat(a + 7), pat(a + 9)});
        for (int a = 0; a < NW; a += 62) begin
            xfer("R4 wide rd", 1'b1, a + 1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 32'h0);
        end
        xfer("R4 wide top b0", 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h03FE, 32'h1234_ABCD);
        xfer("R4 wide top b0 rd", 1'b1, 16'h03FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h03FE, 32'h0);
        xfer("R4 wide top b1", 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h07FE, 32'hCAFE_0F0F);
        xfer("R4 wide top b1 rd", 1'b1, 16'h07FF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h07FE, 32'h0);

        // R5: odd 32-bit write and read
        xfer("R5 odd wr", 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0101, 32'hFFFF_FFFF);
        xfer("R5 odd rd", 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0401, 32'h0);
        idle();
        xfer("R5 after odd", 1'b1, 16'h0101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 32'h0);

        // R6/R7: byte writes and reads
        for (int a = 5; a < NW; a += 301) begin
            xfer("R6 lo wr", 1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, a, 32'hFFFF_FF3C);
            xfer("R7 lo rd", 1'b1, a, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, a, 32'h0);
            xfer("R6 hi wr", 1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, a, 32'hFFFF_FFA5);
            xfer("R7 hi rd", 1'b1, a, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a, 32'h0);
            xfer("R6 word rd", 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, a, 32'h0);
        end

        // R8: same-word collision, incl. upper half of a 32-bit write
        xfer("R8 collide", 1'b1, 16'h0222, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0222, 32'h0000_7777);
        xfer("R8 after", 1'b1, 16'h0222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 32'h0);
        xfer("R8 collide wide", 1'b1, 16'h0601, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0600, 32'h8888_9999);
        xfer("R8 after wide", 1'b1, 16'h0601, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0600, 32'h0);

        // R9: out-of-range on both ports
        xfer("R9 miss wr", 1'b1, 16'h0800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0800, 32'h0000_BEEF);
        xfer("R9 miss rd", 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0FFE, 32'h0);
        xfer("R9 odd miss", 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h8001, 32'h0);
        idle();
        xfer("R9 no alias", 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 32'h0);

        // R12: no strobe
        xfer("R12 no strobe wr", 1'b0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0333, 32'h0000_1111);
        xfer("R12 no strobe rd", 1'b1, 16'h0333, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0333, 32'h0);
        idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule